// File: doc/BRIEF.md
# Quarter-Wave Sine and Cosine Generator

This block turns a binary phase into a complex unit phasor. It takes one 12-bit phase word per clock and returns the cosine and the sine of that angle together, as two signed fixed-point numbers. Both values are read from one stored table. That table holds only the first quarter of a sine wave, with 1024 magnitudes, and it is built when the design is elaborated.

The two top phase bits pick a quadrant. The remaining ten bits address the table. The sine read uses the index as it is in even quadrants and uses the mirrored index in odd quadrants. The cosine read does the reverse. A sign fix for each quadrant then rebuilds all four quadrants from the one stored quarter.

The table samples sit half a step into each bin. Because of this, mirroring an index is exact and no output is ever zero. The block is fully pipelined, and a valid flag travels alongside the data.

Top module: `quarter_sincos`

## Requirements
- R1: A phase presented with `in_valid` high at a rising edge produces `out_valid` high with its result exactly three rising edges later. One new phase is accepted on every cycle.
- R2: Phase word p stands for the angle (p + 0.5)·2π/4096. Each output is within 1 LSB of round(32768·cos) and round(32768·sin) of that angle.
- R3: The quadrant is phase[11:10]. The sine is negative (bit 15 set) in quadrants 2 and 3 and positive otherwise. The cosine is negative in quadrants 1 and 2 and positive otherwise.
- R4: No output ever has a magnitude above 32767, and -32768 never appears. Phase 0 gives cosine 32767, phase 1023 gives sine 32767, and phase 2048 gives cosine -32767.
- R5: For phase k in quadrant 0, the cosine is exactly equal to the sine of phase 1023-k, because both come from the same stored entry.
- R6: While `rst` is high at a rising edge, all pipeline stages are cleared. After reset, `out_valid`, `cos_out` and `sin_out` read 0, and any phases that were in flight are discarded.
- R7: Whenever `out_valid` is high, cos²+sin² stays within 1/4096 of 32768².
- R8: Cycles with `in_valid` low produce no output. The number of results equals the number of accepted phases, and the results come out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Phase word is valid this cycle |
| phase | input | 12 | Phase, one full turn over 4096 steps |
| out_valid | output | 1 | Result valid |
| cos_out | output | 16 | Cosine, signed Q1.15 |
| sin_out | output | 16 | Sine, signed Q1.15 |

## Verification
The bound checker checks several properties on every cycle: the three-cycle alignment of the valid flag, the sign pattern for each quadrant against the phase from three cycles earlier, the ban on -32768, the squared-magnitude window, and the cleared state after reset. Only the bench scenarios can show the absolute accuracy of each value against an independent trigonometric reference. The same holds for the exact full-scale values at the quadrant edges, the exact equality of mirrored cosine and sine pairs, and in-order delivery with no loss under random gaps in the input. The bench also covers the loss of in-flight phases when reset arrives mid-stream.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

    localparam int PHASE_W_DEF = 12;
    localparam int OUT_W_DEF   = 16;
    localparam real PI_R       = 3.14159265358979323846;

    typedef enum logic [1:0] {
        QUAD_0 = 2'd0,
        QUAD_1 = 2'd1,
        QUAD_2 = 2'd2,
        QUAD_3 = 2'd3
    } quad_e;

    // Control that travels beside the table addresses and magnitudes
    typedef struct packed {
        logic  vld;
        quad_e quad;
        logic  sin_neg;
        logic  cos_neg;
    } fold_ctl_t;

    // Magnitude of stored entry k: sine sampled half a step into bin k
    function automatic int quarter_entry(int k, int depth, int out_w);
        real ang;
        real full;
        int  lim;
        int  r;
        ang  = (real'(k) + 0.5) * PI_R / (2.0 * real'(depth));
        full = real'(1 << (out_w - 1));
        lim  = (1 << (out_w - 1)) - 1;
        r    = int'($sin(ang) * full);
        if (r > lim) r = lim;
        if (r < 0)   r = 0;
        return r;
    endfunction

    function automatic logic sin_is_neg(quad_e q);
        return (q == QUAD_2) || (q == QUAD_3);
    endfunction

    function automatic logic cos_is_neg(quad_e q);
        return (q == QUAD_1) || (q == QUAD_2);
    endfunction

endpackage

// File: rtl/qsc_fold.sv
module qsc_fold
    import qsc_pkg::*;
#(
    parameter int PHASE_W = PHASE_W_DEF,
    localparam int ADDR_W = PHASE_W - 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [PHASE_W-1:0] phase,
    output logic [ADDR_W-1:0]  sin_addr,
    output logic [ADDR_W-1:0]  cos_addr,
    output fold_ctl_t          ctl
);

    quad_e             quad;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] mirror;
    logic              odd_quad;

    always_comb begin
        quad     = quad_e'(phase[PHASE_W-1 -: 2]);
        idx      = phase[ADDR_W-1:0];
        mirror   = ~idx;               // depth-1 minus index
        odd_quad = phase[ADDR_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_addr <= '0;
            cos_addr <= '0;
            ctl      <= '0;
        end else begin
            sin_addr    <= odd_quad ? mirror : idx;
            cos_addr    <= odd_quad ? idx : mirror;
            ctl.vld     <= in_valid;
            ctl.quad    <= quad;
            ctl.sin_neg <= sin_is_neg(quad);
            ctl.cos_neg <= cos_is_neg(quad);
        end
    end

endmodule

// File: rtl/qsc_rom.sv
module qsc_rom
    import qsc_pkg::*;
#(
    parameter int ADDR_W = PHASE_W_DEF - 2,
    parameter int OUT_W  = OUT_W_DEF,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int MAG_W = OUT_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic [MAG_W-1:0]  data_a,
    output logic [MAG_W-1:0]  data_b
);

    logic [MAG_W-1:0] table_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int VAL = quarter_entry(k, DEPTH, OUT_W);
        assign table_q[k] = MAG_W'(VAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_a <= '0;
            data_b <= '0;
        end else begin
            data_a <= table_q[addr_a];
            data_b <= table_q[addr_b];
        end
    end

endmodule

// File: rtl/qsc_sign.sv
module qsc_sign
    import qsc_pkg::*;
#(
    parameter int OUT_W  = OUT_W_DEF,
    localparam int MAG_W = OUT_W - 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [MAG_W-1:0]        mag_sin,
    input  logic [MAG_W-1:0]        mag_cos,
    input  fold_ctl_t               ctl,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out
);

    logic signed [OUT_W-1:0] s_pos;
    logic signed [OUT_W-1:0] c_pos;

    always_comb begin
        s_pos = $signed({1'b0, mag_sin});
        c_pos = $signed({1'b0, mag_cos});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sin_out   <= '0;
            cos_out   <= '0;
        end else begin
            out_valid <= ctl.vld;
            sin_out   <= ctl.sin_neg ? -s_pos : s_pos;
            cos_out   <= ctl.cos_neg ? -c_pos : c_pos;
        end
    end

endmodule

// File: rtl/quarter_sincos.sv
module quarter_sincos
    import qsc_pkg::*;
#(
    parameter int PHASE_W = PHASE_W_DEF,
    parameter int OUT_W   = OUT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [PHASE_W-1:0]      phase,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] cos_out,
    output logic signed [OUT_W-1:0] sin_out
);

    localparam int ADDR_W = PHASE_W - 2;
    localparam int MAG_W  = OUT_W - 1;

    logic [ADDR_W-1:0] s1_sin_addr;
    logic [ADDR_W-1:0] s1_cos_addr;
    fold_ctl_t         s1_ctl;
    fold_ctl_t         s2_ctl;
    logic [MAG_W-1:0]  s2_sin_mag;
    logic [MAG_W-1:0]  s2_cos_mag;

    // Stage 1: quadrant folding into two table addresses
    qsc_fold #(.PHASE_W(PHASE_W)) u_fold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .phase    (phase),
        .sin_addr (s1_sin_addr),
        .cos_addr (s1_cos_addr),
        .ctl      (s1_ctl)
    );

    // Stage 2: two reads of the shared quarter table
    qsc_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_rom (
        .clk    (clk),
        .rst    (rst),
        .addr_a (s1_sin_addr),
        .addr_b (s1_cos_addr),
        .data_a (s2_sin_mag),
        .data_b (s2_cos_mag)
    );

    always_ff @(posedge clk) begin
        if (rst) s2_ctl <= '0;
        else     s2_ctl <= s1_ctl;
    end

    // Stage 3: sign restoration
    qsc_sign #(.OUT_W(OUT_W)) u_sign (
        .clk       (clk),
        .rst       (rst),
        .mag_sin   (s2_sin_mag),
        .mag_cos   (s2_cos_mag),
        .ctl       (s2_ctl),
        .out_valid (out_valid),
        .sin_out   (sin_out),
        .cos_out   (cos_out)
    );

endmodule

// File: rtl/quarter_sincos_chk.sv
module quarter_sincos_chk #(
    parameter int PHASE_W = 12,
    parameter int OUT_W   = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [PHASE_W-1:0]      phase,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] cos_out,
    input logic signed [OUT_W-1:0] sin_out
);

    localparam longint FULL2 = longint'(1) << (2 * (OUT_W - 1));
    localparam longint TOL2  = FULL2 >> 12;
    localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic [1:0] since_rst;
    longint     mag2;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    always_comb begin
        mag2 = longint'(cos_out) * longint'(cos_out) + longint'(sin_out) * longint'(sin_out);
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3
    quadrant_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && out_valid) |->
            (sin_out[OUT_W-1] == $past(phase[PHASE_W-1], 3)) &&
            (cos_out[OUT_W-1] == ($past(phase[PHASE_W-1], 3) ^ $past(phase[PHASE_W-2], 3))));

    // R4
    no_min_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cos_out != MOST_NEG) && (sin_out != MOST_NEG));

    // R7
    unit_radius_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (mag2 > FULL2 - TOL2) && (mag2 < FULL2 + TOL2));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && cos_out == '0 && sin_out == '0));

endmodule

bind quarter_sincos quarter_sincos_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/quarter_sincos_test.sv
module quarter_sincos_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [11:0]        phase = '0;
    logic               out_valid;
    logic signed [15:0] cos_out;
    logic signed [15:0] sin_out;

    int checks = 0;
    int fails  = 0;
    int produced = 0;
    int accepted = 0;

    typedef struct {
        int p;
        int c;
        int s;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    quarter_sincos uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .phase     (phase),
        .out_valid (out_valid),
        .cos_out   (cos_out),
        .sin_out   (sin_out)
    );

    function automatic int ref_val(int p, bit want_sin);
        real a;
        real v;
        int  r;
        a = (real'(p) + 0.5) * 2.0 * 3.14159265358979323846 / 4096.0;
        v = (want_sin ? $sin(a) : $cos(a)) * 32768.0;
        r = int'(v);
        if (r > 32767)  r = 32767;
        if (r < -32767) r = -32767;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic drive(input bit v, input int p);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        phase    = 12'(p);
        if (v) begin
            e.p = p;
            e.c = ref_val(p, 1'b0);
            e.s = ref_val(p, 1'b1);
            sb.push_back(e);
            accepted++;
        end
    endtask

    // Monitor: compare every result against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            produced++;
            if (sb.size() == 0) begin
                check(1'b0, "R8", "unexpected output", 1, 0);
            end else begin
                exp_t e;
                int dc;
                int ds;
                e  = sb.pop_front();
                dc = int'(cos_out) - e.c;
                ds = int'(sin_out) - e.s;
                check(dc >= -1 && dc <= 1, "R2", $sformatf("cos p=%0d", e.p), int'(cos_out), e.c);
                check(ds >= -1 && ds <= 1, "R2", $sformatf("sin p=%0d", e.p), int'(sin_out), e.s);
                check(sin_out[15] == e.p[11], "R3", $sformatf("sin sign p=%0d", e.p),
                      int'(sin_out[15]), e.p[11]);
                check(cos_out[15] == (e.p[11] ^ e.p[10]), "R3", $sformatf("cos sign p=%0d", e.p),
                      int'(cos_out[15]), e.p[11] ^ e.p[10]);
                check(cos_out != -16'sd32768 && sin_out != -16'sd32768, "R4", "min value",
                      int'(cos_out), 0);
            end
        end
    end

    // Isolated phase: checks exact three-cycle latency and returns values
    task automatic probe(input int p, output int c, output int s);
        drive(1'b1, p);
        drive(1'b0, 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "early valid", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R1", "valid at third edge", int'(out_valid), 1);
        c = int'(cos_out);
        s = int'(sin_out);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c;
        int s;
        int c2;
        int s2;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: reset state
        check(out_valid == 1'b0, "R6", "valid after reset", int'(out_valid), 0);
        check(cos_out == 16'sd0 && sin_out == 16'sd0, "R6", "data after reset", int'(cos_out), 0);

        // R2, R3: full sweep, one phase per cycle
        for (int p = 0; p < 4096; p++) drive(1'b1, p);
        drive(1'b0, 0);
        repeat (6) @(negedge clk);

        // R8: random gaps
        for (int i = 0; i < 3000; i++) drive(1'($urandom_range(0, 1)), int'($urandom_range(0, 4095)));
        drive(1'b0, 0);
        repeat (6) @(negedge clk);
        check(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);
        check(produced == accepted, "R8", "result count", produced, accepted);

        // R4: full-scale corners
        probe(0, c, s);
        check(c == 32767, "R4", "cos at phase 0", c, 32767);
        probe(1023, c, s);
        check(s == 32767, "R4", "sin at phase 1023", s, 32767);
        probe(2048, c, s);
        check(c == -32767, "R4", "cos at phase 2048", c, -32767);
        probe(3072, c, s);
        check(s == -32767, "R4", "sin at phase 3072", s, -32767);

        // R5: mirrored pairs share one entry
        for (int k = 0; k < 1024; k += 137) begin
            probe(k, c, s);
            probe(1023 - k, c2, s2);
            check(c == s2, "R5", $sformatf("cos(%0d) vs sin(%0d)", k, 1023 - k), c, s2);
        end

        // R6: reset mid-stream drops in-flight phases
        drive(1'b1, 100);
        drive(1'b1, 200);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        sb.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R6", "in-flight dropped", int'(out_valid), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule